// File: doc/BRIEF.md
# Two-Half Sector Hamming Code Generator

This block builds a single-error-correcting Hamming code for a 512-byte flash sector while the sector's bytes stream through the data path. The sector is handled as two independent 256-byte halves. Each half gets 16 line-parity bits and 6 column-parity bits. The host can then correct one flipped bit in each half.

Three mode codes control the block, all written through a mode strobe:
- **Clear (0xF4)** empties both accumulators and the byte counter.
- **Accumulate (0xB4)** folds every following valid byte into the half that the byte counter selects.
- **Result (0xD4)** turns the 16-bit read port into a three-word sequence that carries the six code bytes in an interleaved order. After the third word the block drops back to plain data mode (0x94) by itself.

Software normally issues one dummy data read after the clear, before it selects accumulate. A byte seen in that window is not counted.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset, `mode_o` reads 0x94 and `rd_data_o` is 0. A result read with no accumulated bytes returns 0xFFFF for all three words.
- R2: A mode write of 0xF4 clears both halves' parity and the byte counter. A result read that follows returns 0xFFFF three times.
- R3: Bytes are accumulated only while the mode register holds 0xB4. A valid byte in any other mode, including the dummy read after a clear, changes nothing. Leaving 0xB4 and returning resumes at the same byte position.
- R4: For byte index i inside a half (0..255) with row parity p (XOR of its 8 bits), line bit LP(2k) toggles with p when bit k of i is 0, and LP(2k+1) toggles when bit k of i is 1, for k = 0..7.
- R5: Column bit CP(2j) is the XOR, over all bytes of the half, of the data bits whose bit position has bit j equal to 0. CP(2j+1) covers the positions where bit j is 1, for j = 0..2. The column code byte is {CP5..CP0, 1, 1}, with CP5 in bit 7.
- R6: All parity bits are returned inverted: code byte A is ~LP7..LP0, code byte B is ~LP15..LP8, and code byte C is {~CP5..~CP0, 2'b11}. A half of all 0xFF bytes therefore yields 0xFF in all three code bytes.
- R7: Accepted bytes 0..255 go to half 0 and bytes 256..511 go to half 1. Valid bytes after the 512th are ignored until the next clear.
- R8: In result mode the three reads return {A0, B0}, {A1, C0} and {C1, B1}, with the first byte named in bits 15:8. The digit gives the half.
- R9: The read that returns the third word sets the mode back to 0x94. Outside result mode `rd_data_o` is 0.
- R10: Writing 0xD4 again restarts the read sequence at the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_i | input | 8 | Mode code written on the strobe |
| byte_vld_i | input | 1 | A data byte passes the data path this cycle |
| byte_i | input | 8 | Data byte |
| rd_en_i | input | 1 | Read strobe of the 16-bit data register |
| rd_data_o | output | 16 | Result word in result mode, otherwise 0 |
| mode_o | output | 8 | Current mode code |

## Verification
On every cycle, assertions check that:
- the byte counter never passes the sector end;
- a clear empties both accumulators on the next edge;
- an idle accumulator and an idle counter hold their values;
- the read index stays within three words and restarts on a result-mode write;
- the third read hands control back to data mode.

Whether the parity bits land in the right positions, inverted and interleaved correctly across the two halves, only shows through the bench's scenarios. These scenarios compare the read words against a model that computes the codes straight from the byte stream. They cover patterned data, all-ones data, a lone set bit in the second half, paused accumulation and overrun bytes.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

   localparam logic [7:0] MODE_DATA    = 8'h94;
   localparam logic [7:0] MODE_CALC    = 8'hB4;
   localparam logic [7:0] MODE_RESULT  = 8'hD4;
   localparam logic [7:0] MODE_ECC_CLR = 8'hF4;

   localparam int CP_W = 6;

   // Column parity of one byte: bit 2j covers positions with bit j clear,
   // bit 2j+1 covers positions with bit j set.
   function automatic logic [CP_W-1:0] col_parity(input logic [7:0] b);
      logic [CP_W-1:0] r;
      r = '0;
      for (int j = 0; j < 3; j++) begin
         for (int p = 0; p < 8; p++) begin
            if (((p >> j) & 1) == 1) r[2*j+1] = r[2*j+1] ^ b[p];
            else                     r[2*j]   = r[2*j]   ^ b[p];
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/nand_ecc_half_acc.sv
module nand_ecc_half_acc
   import nand_ecc_pkg::*;
#(
   parameter int IDX_W = 8,
   localparam int LP_W = 2 * IDX_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [7:0]       byte_i,
   output logic [LP_W-1:0]  lp_o,
   output logic [CP_W-1:0]  cp_o
);

   logic [LP_W-1:0] lp_q, lp_nxt;
   logic [CP_W-1:0] cp_q;
   logic            row_par;

   always_comb begin
      row_par = ^byte_i;
      for (int k = 0; k < IDX_W; k++) begin
         lp_nxt[2*k]   = lp_q[2*k]   ^ (row_par & ~idx_i[k]);
         lp_nxt[2*k+1] = lp_q[2*k+1] ^ (row_par &  idx_i[k]);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lp_q <= '0;
         cp_q <= '0;
      end else if (clr_i) begin
         lp_q <= '0;
         cp_q <= '0;
      end else if (en_i) begin
         lp_q <= lp_nxt;
         cp_q <= cp_q ^ col_parity(byte_i);
      end
   end

   assign lp_o = lp_q;
   assign cp_o = cp_q;

   // R2: a clear leaves empty parity on the next edge
   a_r2_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (lp_q == '0 && cp_q == '0));

   // R3: without enable the parity holds
   a_r3_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !clr_i) |=> ($stable(lp_q) && $stable(cp_q)));

endmodule

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
   import nand_ecc_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int RD_WORDS = 3,
   localparam int CNT_W = IDX_W + 2,
   localparam int RI_W = $clog2(RD_WORDS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             mode_wr_i,
   input  logic [7:0]       mode_i,
   input  logic             byte_vld_i,
   input  logic             rd_en_i,
   output logic             clr_o,
   output logic             acc_en_o,
   output logic             half_sel_o,
   output logic [IDX_W-1:0] byte_idx_o,
   output logic [RI_W-1:0]  rd_idx_o,
   output logic             res_mode_o,
   output logic [7:0]       mode_o
);

   localparam logic [CNT_W-1:0] SECTOR_BYTES = CNT_W'(1) << (IDX_W + 1);
   localparam logic [RI_W-1:0]  LAST_WORD    = RI_W'(RD_WORDS - 1);

   logic [7:0]       mode_q;
   logic [CNT_W-1:0] cnt_q;
   logic [RI_W-1:0]  idx_q;

   assign clr_o      = mode_wr_i && (mode_i == MODE_ECC_CLR);
   assign res_mode_o = (mode_q == MODE_RESULT);
   assign acc_en_o   = (mode_q == MODE_CALC) && byte_vld_i &&
                       (cnt_q < SECTOR_BYTES) && !clr_o;
   assign half_sel_o = cnt_q[IDX_W];
   assign byte_idx_o = cnt_q[IDX_W-1:0];
   assign rd_idx_o   = idx_q;
   assign mode_o     = mode_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_o) begin
         cnt_q <= '0;
      end else if (acc_en_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= MODE_DATA;
         idx_q  <= '0;
      end else if (mode_wr_i) begin
         mode_q <= mode_i;
         if (mode_i == MODE_RESULT) idx_q <= '0;
      end else if (rd_en_i && res_mode_o) begin
         if (idx_q == LAST_WORD) begin
            mode_q <= MODE_DATA;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   // R7: the counter never runs past the sector end
   a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= SECTOR_BYTES);

   // R3: the counter is frozen outside accumulate mode
   a_r3_cnt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q != MODE_CALC && !mode_wr_i) |=> $stable(cnt_q));

   // R8: read index stays inside the word sequence
   a_r8_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idx_q <= LAST_WORD);

   // R9: the last result read returns to data mode
   a_r9_back_to_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && res_mode_o && idx_q == LAST_WORD && !mode_wr_i)
      |=> (mode_q == MODE_DATA));

   // R10: entering result mode restarts at the first word
   a_r10_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_wr_i && mode_i == MODE_RESULT) |=> (idx_q == '0 && res_mode_o));

endmodule

// File: rtl/nand_ecc_result_mux.sv
module nand_ecc_result_mux
   import nand_ecc_pkg::*;
#(
   parameter int LP_W = 16,
   parameter int RI_W = 2
) (
   input  logic            res_mode_i,
   input  logic [RI_W-1:0] idx_i,
   input  logic [LP_W-1:0] lp0_i,
   input  logic [CP_W-1:0] cp0_i,
   input  logic [LP_W-1:0] lp1_i,
   input  logic [CP_W-1:0] cp1_i,
   output logic [15:0]     rd_data_o
);

   localparam int HB = LP_W / 2;

   logic [HB-1:0] a0, b0, a1, b1;
   logic [7:0]    c0, c1;

   assign a0 = ~lp0_i[HB-1:0];
   assign b0 = ~lp0_i[LP_W-1:HB];
   assign a1 = ~lp1_i[HB-1:0];
   assign b1 = ~lp1_i[LP_W-1:HB];
   assign c0 = {~cp0_i, 2'b11};
   assign c1 = {~cp1_i, 2'b11};

   always_comb begin
      rd_data_o = '0;
      if (res_mode_i) begin
         case (idx_i)
            RI_W'(0): rd_data_o = {a0, b0};
            RI_W'(1): rd_data_o = {a1, c0};
            RI_W'(2): rd_data_o = {c1, b1};
            default:  rd_data_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
   import nand_ecc_pkg::*;
#(
   parameter int IDX_W = 8,
   localparam int LP_W = 2 * IDX_W,
   localparam int NUM_HALVES = 2,
   localparam int RD_WORDS = 3,
   localparam int RI_W = $clog2(RD_WORDS)
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        mode_wr_i,
   input  logic [7:0]  mode_i,
   input  logic        byte_vld_i,
   input  logic [7:0]  byte_i,
   input  logic        rd_en_i,
   output logic [15:0] rd_data_o,
   output logic [7:0]  mode_o
);

   if (IDX_W != 8) begin : g_bad_idx
      $error("IDX_W must be 8: the result words pack 8-bit line-parity bytes");
   end

   logic             clr, acc_en, half_sel, res_mode;
   logic [IDX_W-1:0] byte_idx;
   logic [RI_W-1:0]  rd_idx;
   logic [LP_W-1:0]  lp [NUM_HALVES];
   logic [CP_W-1:0]  cp [NUM_HALVES];

   nand_ecc_ctrl #(.IDX_W(IDX_W), .RD_WORDS(RD_WORDS)) ctrl_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_wr_i  (mode_wr_i),
      .mode_i     (mode_i),
      .byte_vld_i (byte_vld_i),
      .rd_en_i    (rd_en_i),
      .clr_o      (clr),
      .acc_en_o   (acc_en),
      .half_sel_o (half_sel),
      .byte_idx_o (byte_idx),
      .rd_idx_o   (rd_idx),
      .res_mode_o (res_mode),
      .mode_o     (mode_o)
   );

   for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
      nand_ecc_half_acc #(.IDX_W(IDX_W)) acc_i (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .clr_i  (clr),
         .en_i   (acc_en && (half_sel == 1'(h))),
         .idx_i  (byte_idx),
         .byte_i (byte_i),
         .lp_o   (lp[h]),
         .cp_o   (cp[h])
      );
   end

   nand_ecc_result_mux #(.LP_W(LP_W), .RI_W(RI_W)) mux_i (
      .res_mode_i (res_mode),
      .idx_i      (rd_idx),
      .lp0_i      (lp[0]),
      .cp0_i      (cp[0]),
      .lp1_i      (lp[1]),
      .cp1_i      (cp[1]),
      .rd_data_o  (rd_data_o)
   );

endmodule

// File: tb/nand_ecc_gen_tb_top.sv
module nand_ecc_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr = 1'b0;
   logic [7:0]  mode = 8'h00;
   logic        vld = 1'b0;
   logic [7:0]  data = 8'h00;
   logic        rd_en = 1'b0;
   logic [15:0] rd_data;
   logic [7:0]  mode_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [7:0]  model [512];
   int          model_cnt = 0;
   logic [15:0] exp_q [$];
   string       tag_q [$];

   always #2 clk = ~clk;

   nand_ecc_gen dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .mode_wr_i  (mode_wr),
      .mode_i     (mode),
      .byte_vld_i (vld),
      .byte_i     (data),
      .rd_en_i    (rd_en),
      .rd_data_o  (rd_data),
      .mode_o     (mode_out)
   );

   // monitor: pops one expected word per read strobe
   always @(negedge clk) begin
      if (rd_en) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected read: actual %h expected none", rd_data);
         end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rd_data !== e) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", t, rd_data, e);
            end
         end
      end
   end

   task automatic write_mode(input logic [7:0] c);
      mode_wr = 1'b1; mode = c;
      @(posedge clk); #1;
      mode_wr = 1'b0;
      if (c == 8'hF4) begin
         for (int i = 0; i < 512; i++) model[i] = 8'h00;
         model_cnt = 0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input bit counted);
      vld = 1'b1; data = b;
      @(posedge clk); #1;
      vld = 1'b0;
      if (counted && model_cnt < 512) begin
         model[model_cnt] = b;
         model_cnt++;
      end
   endtask

   task automatic read_word(input logic [15:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      rd_en = 1'b1;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic check_port(input logic [15:0] act, input logic [15:0] e, input string t);
      n_cmp++;
      if (act !== e) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", t, act, e);
      end
   endtask

   task automatic check_idle(input string t);
      @(negedge clk);
      check_port({8'h00, mode_out}, 16'h0094, {t, " mode"});
      check_port(rd_data, 16'h0000, {t, " rd_data"});
      @(posedge clk); #1;
   endtask

   // reference code bytes for one half: {A, B, C}
   function automatic logic [23:0] half_code(input int base);
      logic [15:0] lp;
      logic [5:0]  cp;
      lp = '0; cp = '0;
      for (int i = 0; i < 256; i++) begin
         logic p;
         p = ^model[base + i];
         for (int k = 0; k < 8; k++) begin
            if (((i >> k) & 1) == 1) lp[2*k+1] ^= p;
            else                     lp[2*k]   ^= p;
         end
         for (int bp = 0; bp < 8; bp++) begin
            for (int j = 0; j < 3; j++) begin
               if (((bp >> j) & 1) == 1) cp[2*j+1] ^= model[base + i][bp];
               else                      cp[2*j]   ^= model[base + i][bp];
            end
         end
      end
      return {~lp[7:0], ~lp[15:8], ~cp, 2'b11};
   endfunction

   task automatic read_all(input string t);
      logic [23:0] h0, h1;
      h0 = half_code(0);
      h1 = half_code(256);
      write_mode(8'hD4);
      read_word({h0[23:16], h0[15:8]}, {t, " R8 word0"});
      read_word({h1[23:16], h0[7:0]},  {t, " R8 word1"});
      read_word({h1[7:0],  h1[15:8]},  {t, " R8 word2"});
      check_idle({t, " R9 after third read"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 512; i++) model[i] = 8'h00;
      repeat (3) @(posedge clk); #1;
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R1: reset state and empty result
      check_idle("R1 reset");
      write_mode(8'hD4);
      read_word(16'hFFFF, "R1 empty w0");
      read_word(16'hFFFF, "R1 empty w1");
      read_word(16'hFFFF, "R1 empty w2");
      check_idle("R1 R9 return");

      // R4 R5 R7 R3: patterned sector, dummy byte, overrun bytes
      write_mode(8'hF4);
      send_byte(8'hA5, 1'b0);          // R3 dummy read while clearing mode
      write_mode(8'hB4);
      for (int i = 0; i < 512; i++)
         send_byte(8'((i * 37 + 5) ^ (i >> 3)), 1'b1);
      for (int i = 0; i < 4; i++) send_byte(8'h5A + 8'(i), 1'b0);  // R7 overrun
      read_all("R4 R5 R7 pattern");

      // R6: all-ones sector
      write_mode(8'hF4);
      write_mode(8'hB4);
      for (int i = 0; i < 512; i++) send_byte(8'hFF, 1'b1);
      write_mode(8'hD4);
      read_word(16'hFFFF, "R6 ones w0");
      read_word(16'hFFFF, "R6 ones w1");
      read_word(16'hFFFF, "R6 ones w2");

      // R3 pause, lone bit in half 1
      write_mode(8'hF4);
      write_mode(8'hB4);
      for (int i = 0; i < 100; i++) send_byte(8'h00, 1'b1);
      write_mode(8'h94);
      for (int i = 0; i < 5; i++) send_byte(8'hC3, 1'b0);  // R3 ignored
      write_mode(8'hB4);
      for (int i = 100; i < 512; i++) send_byte((i == 300) ? 8'h10 : 8'h00, 1'b1);
      read_all("R3 R7 lone bit");

      // partial sector: half 1 stays empty
      write_mode(8'hF4);
      write_mode(8'hB4);
      for (int i = 0; i < 10; i++) send_byte(8'(8'h81 + 8'(i * 3)), 1'b1);
      read_all("R7 partial");

      // R10: restart read sequence
      begin
         logic [23:0] h0, h1;
         h0 = half_code(0);
         h1 = half_code(256);
         write_mode(8'hD4);
         read_word({h0[23:16], h0[15:8]}, "R10 first");
         write_mode(8'hD4);
         read_word({h0[23:16], h0[15:8]}, "R10 restart w0");
         read_word({h1[23:16], h0[7:0]},  "R10 restart w1");
         read_word({h1[7:0],  h1[15:8]},  "R10 restart w2");
      end

      // R2: clear then read
      write_mode(8'hF4);
      write_mode(8'hD4);
      read_word(16'hFFFF, "R2 cleared w0");
      read_word(16'hFFFF, "R2 cleared w1");
      read_word(16'hFFFF, "R2 cleared w2");
      check_idle("R2 R9 end");

      @(posedge clk); #1;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule